// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable model of a serial EEPROM with 512 words of 16 bits. It has a select line, a serial clock and a data-in line, plus a data-out line with its own enable for a tri-state pad. Everything is sampled on a fast system clock. A rising edge of the serial clock is found by comparing the serial clock with its value one system cycle earlier. While select is high, data-in is taken on every such edge. Leading samples of 0 are ignored. The first 1 starts a 13-clock frame: the start bit, a two-bit opcode, one pad bit, then address bits A8 down to A0.

The frame can request a read, a single-word write, a single-word erase, a write of every word or an erase of every word. It can also set or clear the write-enable latch. A read streams words out most significant bit first and steps the address until select drops. The four write-class commands arm a programming cycle that begins when select falls. A parameterised cycle counter stands in for the programming time. While it runs, the serial inputs are ignored, and raising select shows busy (0) or ready (1) on data-out. A power-good input stands in for the supply monitor. When it drops, the enable latch is cleared and any programming in progress is abandoned.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While select is low, the data-out enable is 0 and serial clock edges are not decoded. Data-out is also undriven after reset, before any command.
- R2: Serial clock edges sampled with data-in 0 before the start bit leave the block waiting for the start bit. A frame preceded by such dummy clocks runs the same as one without them.
- R3: After the start bit, 12 bits are taken: opcode (first two), a pad bit, then A8..A0. The opcodes are 10 for read, 01 for write and 11 for erase. For opcode 00, the pad bit and A8 form a sub-code: 01 write-all, 10 erase-all, 11 write-enable, 00 write-disable.
- R4: On a read, data-out is enabled and shows 0 once A0 has been taken. Each later serial clock edge then shows the next data bit, D15 first.
- R5: If clocks continue on a read, the next word follows the 16th bit of the current word with no gap. The address wraps from 511 to 0.
- R6: Write and write-all store the last 16 data bits taken before select falls, however many more arrive.
- R7: Programming begins only when select falls after a complete write-class frame, which for write and write-all includes at least 16 data bits. A frame cut short by select falling changes no word and starts no programming.
- R8: Erase sets the addressed word to 16'hFFFF. Erase-all sets every word to 16'hFFFF. Write-all stores its data in every word.
- R9: The write-enable latch is clear after reset, set by write-enable and cleared by write-disable. A write-class command with the latch clear changes nothing and shows no status.
- R10: A low power-good clears the latch and cancels any programming, so the word is left unchanged. A power-good drop in the same cycle as select falling starts no programming.
- R11: During programming, select high drives data-out to 0, and serial clock and data-in are ignored. Once programming ends, select high drives data-out to 1.
- R12: While ready is shown, a start bit sampled on a serial clock edge turns the data-out enable off at once. The frame it starts is then decoded normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply-good indication; low clears write enable and aborts programming |
| cs | input | 1 | Chip select, high to select |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out, or busy/ready status |
| dout_oe | output | 1 | Output enable for the data-out pad |

## Verification
Two functions can land in the same system cycle. The first is select falling, which arms programming after a full write frame. The second is power-good dropping, which must veto that programming. The bench drives both edges on the same clock. It then judges the result at the ports: no busy or ready status appears when select is raised again, and a read of the word returns its old contents. The start-bit release of data-out can also meet the ready status in a single cycle. This is provoked by raising select after programming, clocking in a start bit, checking that the enable has dropped, and finishing that frame as a read.

// File: rtl/mw_pkg.sv
// Shared types for the serial EEPROM slave: decoded commands and
// sequencer states. Assumes the opcode and sub-code encodings of R3.
package mw_pkg;

    typedef enum logic [2:0] {
        CMD_READ, CMD_WRITE, CMD_ERASE, CMD_WRALL,
        CMD_ERALL, CMD_WEN, CMD_WDS
    } cmd_t;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_READ, S_DATA, S_ARMED, S_HOLD, S_BUSY
    } fsm_t;

    // Map the two opcode bits and the two sub-code bits to a command.
    function automatic cmd_t decode_cmd(input logic [1:0] op, input logic [1:0] sub);
        cmd_t c;
        case (op)
            2'b10:   c = CMD_READ;
            2'b01:   c = CMD_WRITE;
            2'b11:   c = CMD_ERASE;
            default: begin
                case (sub)
                    2'b01:   c = CMD_WRALL;
                    2'b10:   c = CMD_ERALL;
                    2'b11:   c = CMD_WEN;
                    default: c = CMD_WDS;
                endcase
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mw_sk_edge.sv
// Serial clock rising-edge finder. Assumes sk is already clean and
// slower than clk, so that each high phase spans at least one clk.
module mw_sk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    output logic rise
);
    logic sk_q;

    // Keep last cycle's serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sk;
    end

    assign rise = sk & ~sk_q;
endmodule

// File: rtl/mw_prog_timer.sv
// Programming delay counter. A start pulse loads CYCLES. done pulses in
// the last counting cycle unless abort is high, and abort empties the
// counter. Assumes start never comes while busy.
module mw_prog_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Load, count down, or clear on abort.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (abort) cnt <= '0;
        else if (start) cnt <= CNT_W'(CYCLES);
        else if (busy)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1)) && !abort;
endmodule

// File: rtl/mw_word_array.sv
// Register-based word store. Reset fills it with all ones (erased). One
// word or every word is written per cycle; the read is combinational.
module mw_word_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_one,
    input  logic              we_all,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Erase on reset; single-word or whole-array update afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (we_all || (we_one && waddr == ADDR_W'(i))) mem[i] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mw_eeprom_slave.sv
// Serial EEPROM slave top. Decodes frames taken on serial clock edges
// while select is high, streams reads, arms programming on select fall,
// and reports busy/ready. Assumes cs, sk and di are synchronous to clk.
module mw_eeprom_slave
    import mw_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 16,
    parameter int PAD_W       = 1,
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout,
    output logic dout_oe
);
    localparam int FIELD_W = ADDR_W + PAD_W;
    localparam int FRAME_W = 2 + FIELD_W;
    localparam int FCNT_W  = $clog2(FRAME_W);
    localparam int DCNT_W  = $clog2(DATA_W + 1);
    localparam int RBIT_W  = $clog2(DATA_W);

    fsm_t              state;
    cmd_t              cmd_q;
    logic [FRAME_W-2:0] fr_sr;
    logic [FCNT_W-1:0] fcnt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_sr;
    logic [DCNT_W-1:0] dcnt;
    logic [DATA_W-1:0] rd_sr;
    logic              rd_bit;
    logic [RBIT_W-1:0] rbit;
    logic              wen_q;
    logic              ready_q;

    logic              sk_rise;
    logic              tmr_busy;
    logic              tmr_done;
    logic              prog_go;
    logic              dfull;
    logic [FRAME_W-1:0] frame_w;
    logic [ADDR_W-1:0] faddr;
    logic [ADDR_W-1:0] raddr;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] wdata;
    logic              we_one;
    logic              we_all;
    cmd_t              dec;

    mw_sk_edge u_edge (.clk(clk), .rst_n(rst_n), .sk(sk), .rise(sk_rise));

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(prog_go), .abort(!pwr_good),
        .busy(tmr_busy), .done(tmr_done)
    );

    mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .we_one(we_one), .we_all(we_all),
        .waddr(addr_q), .wdata(wdata), .raddr(raddr), .rdata(rdata)
    );

    // Frame fields as they stand once the current bit is included.
    always_comb begin
        frame_w = {fr_sr, di};
        faddr   = frame_w[ADDR_W-1:0];
        dec     = decode_cmd(frame_w[FRAME_W-1 -: 2], frame_w[FIELD_W-1 -: 2]);
        raddr   = (state == S_CMD) ? faddr : addr_q + 1'b1;
    end

    // Programming launch and array write controls.
    always_comb begin
        dfull   = (dcnt == DCNT_W'(DATA_W));
        prog_go = !cs && wen_q && pwr_good &&
                  ((state == S_DATA && dfull) || state == S_ARMED);
        we_all  = tmr_done && (cmd_q == CMD_WRALL || cmd_q == CMD_ERALL);
        we_one  = tmr_done && (cmd_q == CMD_WRITE || cmd_q == CMD_ERASE);
        wdata   = (cmd_q == CMD_ERASE || cmd_q == CMD_ERALL) ? '1 : data_sr;
    end

    // Command sequencer: start detect, frame shift, read stream, data shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE; cmd_q <= CMD_WDS; fr_sr <= '0; fcnt <= '0;
            addr_q <= '0; data_sr <= '0; dcnt <= '0; rd_sr <= '0;
            rd_bit <= 1'b0; rbit <= '0; wen_q <= 1'b0; ready_q <= 1'b0;
        end else begin
            if (prog_go) ready_q <= 1'b1;
            if (state == S_BUSY) begin
                if (!tmr_busy) state <= S_IDLE;
            end else if (!cs) begin
                state <= prog_go ? S_BUSY : S_IDLE;
            end else if (sk_rise) begin
                case (state)
                    S_IDLE: if (di) begin
                        state   <= S_CMD;
                        fcnt    <= '0;
                        ready_q <= 1'b0;
                    end
                    S_CMD: begin
                        fr_sr <= frame_w[FRAME_W-2:0];
                        fcnt  <= fcnt + 1'b1;
                        if (fcnt == FCNT_W'(FRAME_W - 1)) begin
                            cmd_q  <= dec;
                            addr_q <= faddr;
                            dcnt   <= '0;
                            case (dec)
                                CMD_READ: begin
                                    state  <= S_READ;
                                    rd_sr  <= rdata;
                                    rd_bit <= 1'b0;
                                    rbit   <= '0;
                                end
                                CMD_WRITE, CMD_WRALL: state <= S_DATA;
                                CMD_ERASE, CMD_ERALL: state <= S_ARMED;
                                CMD_WEN: begin wen_q <= 1'b1; state <= S_HOLD; end
                                default: begin wen_q <= 1'b0; state <= S_HOLD; end
                            endcase
                        end
                    end
                    S_READ: begin
                        rd_bit <= rd_sr[DATA_W-1];
                        rbit   <= rbit + 1'b1;
                        if (rbit == RBIT_W'(DATA_W - 1)) begin
                            rd_sr  <= rdata;
                            addr_q <= addr_q + 1'b1;
                        end else begin
                            rd_sr <= rd_sr << 1;
                        end
                    end
                    S_DATA: begin
                        data_sr <= {data_sr[DATA_W-2:0], di};
                        if (!dfull) dcnt <= dcnt + 1'b1;
                    end
                    default: ;
                endcase
            end
            if (!pwr_good) begin
                wen_q   <= 1'b0;
                ready_q <= 1'b0;
            end
        end
    end

    // Pad drive: read data, or busy (0) / ready (1) status.
    always_comb begin
        dout_oe = cs && (ready_q || state == S_READ);
        dout    = tmr_busy ? 1'b0 : ((state == S_READ) ? rd_bit : 1'b1);
    end
endmodule

// File: rtl/mw_eeprom_checker.sv
// Property checker for the serial EEPROM slave, bound into every
// instance of the top. Reads ports and a few internal nets.
module mw_eeprom_checker
    import mw_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic cs,
    input logic di,
    input logic dout,
    input logic dout_oe,
    input logic sk_rise,
    input logic tmr_busy,
    input logic wen_q,
    input fsm_t state
);
    AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !dout_oe);                                            // R1
    AST_BUSY_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_busy && dout_oe) |-> !dout);                             // R11
    AST_PROG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_busy) |-> $past(wen_q));                            // R9
    AST_POWER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !tmr_busy);                                     // R10
    AST_START_RELEASES_DO: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && sk_rise && di && state == S_IDLE) |=> !dout_oe);       // R12
endmodule

bind mw_eeprom_slave mw_eeprom_checker u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs(cs), .di(di),
    .dout(dout), .dout_oe(dout_oe), .sk_rise(sk_rise),
    .tmr_busy(tmr_busy), .wen_q(wen_q), .state(state)
);

// File: tb/sim_mw_eeprom_slave.sv
module sim_mw_eeprom_slave;
    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 40;
    localparam int DEPTH      = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b1;
    logic cs = 1'b0;
    logic sk = 1'b0;
    logic di = 1'b0;
    logic dout;
    logic dout_oe;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] mem_m [DEPTH];

    mw_eeprom_slave #(.PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs(cs),
        .sk(sk), .di(di), .dout(dout), .dout_oe(dout_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One serial clock with data-in d; samples data-out after the edge.
    task automatic pulse(input logic d, output logic q, output logic oe);
        @(negedge clk) di = d;
        @(negedge clk) sk = 1'b1;
        @(negedge clk);
        @(negedge clk) begin q = dout; oe = dout_oe; sk = 1'b0; end
        @(negedge clk);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        logic q, o;
        for (int i = n - 1; i >= 0; i--) pulse(v[i], q, o);
    endtask

    task automatic cs_hi();
        @(negedge clk) cs = 1'b1;
    endtask

    task automatic cs_lo();
        @(negedge clk) begin cs = 1'b0; di = 1'b0; end
        @(negedge clk);
    endtask

    task automatic frame(input logic [1:0] op, input logic [9:0] field);
        cs_hi();
        send(1, 1);
        send({30'd0, op}, 2);
        send({22'd0, field}, 10);
    endtask

    task automatic special(input logic [1:0] sub);
        frame(2'b00, {sub, 8'h00});
        cs_lo();
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        frame(2'b01, {1'b0, a});
        send({16'd0, d}, 16);
        cs_lo();
    endtask

    // Raise select and judge status: busy then ready, or nothing at all.
    task automatic verify(input logic go, input string tag);
        cs_hi();
        @(negedge clk);
        if (go) begin
            chk({tag, " busy"}, {dout_oe, dout}, 2'b10);
            repeat (PROG + 5) @(negedge clk);
            chk({tag, " ready"}, {dout_oe, dout}, 2'b11);
        end else begin
            chk({tag, " no status"}, {31'd0, dout_oe}, 32'd0);
        end
        cs_lo();
    endtask

    // Opcode, address and stream; start bit already sent, select high.
    task automatic rd_body(input logic [8:0] a, input int nw, input string tag);
        logic q, o;
        logic [15:0] w;
        logic [9:0] field;
        field = {1'b0, a};
        send(2, 2);
        send({22'd0, field} >> 1, 9);
        pulse(field[0], q, o);
        chk({tag, " R4 dummy zero"}, {o, q}, 2'b10);
        for (int k = 0; k < nw; k++) begin
            w = '0;
            for (int b = 0; b < 16; b++) begin
                pulse(1'b0, q, o);
                w = {w[14:0], q};
            end
            chk($sformatf("%s word %0d", tag, (a + k) % DEPTH), {16'd0, w},
                {16'd0, mem_m[(a + k) % DEPTH]});
        end
    endtask

    task automatic rd_chk(input logic [8:0] a, input int nw, input string tag);
        cs_hi();
        send(1, 1);
        rd_body(a, nw, tag);
        cs_lo();
        chk({tag, " R1 released"}, {31'd0, dout_oe}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic q, o;
        logic [15:0] v;
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 16'hFFFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset oe", {31'd0, dout_oe}, 32'd0);

        // R1: serial clocks with select low, then select high: nothing driven.
        send(32'h1, 3);
        cs_hi();
        @(negedge clk);
        chk("R1 standby clocks ignored", {31'd0, dout_oe}, 32'd0);
        cs_lo();

        // R9: latch clear after reset, write has no effect.
        wr(9'd3, 16'h1234);
        verify(1'b0, "R9 disabled write");
        rd_chk(9'd3, 1, "R9 unchanged");

        // R3 / R2: enable, then a write preceded by dummy clocks.
        special(2'b11);
        cs_hi();
        send(0, 5);
        send(1, 1);
        send(1, 2);
        send(5, 10);
        send(32'hA5A5, 16);
        cs_lo();
        mem_m[5] = 16'hA5A5;

        // R12: ready shown, start bit releases DO, frame continues as a read.
        cs_hi();
        @(negedge clk);
        chk("R11 busy after dummy write", {dout_oe, dout}, 2'b10);
        repeat (PROG + 5) @(negedge clk);
        chk("R11 ready", {dout_oe, dout}, 2'b11);
        pulse(1'b1, q, o);
        chk("R12 start bit releases", {31'd0, o}, 32'd0);
        rd_body(9'd5, 1, "R12 R2 read after release");
        cs_lo();

        // R3: writes at the address extremes and in the middle.
        foreach (mem_m[i]) begin
            if (i == 0 || i == 1 || i == 255 || i == 256 || i == 510 || i == 511) begin
                v = 16'(i * 16'h0101) ^ 16'h5A3C;
                wr(9'(i), v);
                mem_m[i] = v;
                verify(1'b1, "R3 write");
            end
        end
        rd_chk(9'd255, 2, "R3 R4 read");

        // R6: 32 data bits, last 16 kept.
        frame(2'b01, 10'd100);
        send(32'hDEADBEEF, 32);
        cs_lo();
        mem_m[100] = 16'hBEEF;
        verify(1'b1, "R6 overlong");
        rd_chk(9'd100, 1, "R6 last bits");

        // R7: short data and short address frames are discarded.
        frame(2'b01, 10'd101);
        send(32'h3FF, 10);
        cs_lo();
        verify(1'b0, "R7 short data");
        cs_hi();
        send(1, 1);
        send(32'h1F, 6);
        cs_lo();
        verify(1'b0, "R7 short address");
        rd_chk(9'd101, 1, "R7 unchanged");

        // R8: single-word erase.
        frame(2'b11, 10'd5);
        cs_lo();
        mem_m[5] = 16'hFFFF;
        verify(1'b1, "R8 erase");
        rd_chk(9'd5, 1, "R8 erased word");

        // R5: sequential read across the wrap.
        rd_chk(9'd509, 5, "R5 wrap");

        // R9: write-disable blocks writes.
        special(2'b00);
        wr(9'd7, 16'h7777);
        verify(1'b0, "R9 after disable");
        rd_chk(9'd7, 1, "R9 word 7");

        // R10: power drop mid-programming cancels and clears latch.
        special(2'b11);
        wr(9'd9, 16'h1111);
        cs_hi();
        repeat (10) @(negedge clk);
        pwr_good = 1'b0;
        repeat (2) @(negedge clk);
        pwr_good = 1'b1;
        @(negedge clk);
        chk("R10 status cleared", {31'd0, dout_oe}, 32'd0);
        cs_lo();
        wr(9'd9, 16'h2222);
        verify(1'b0, "R10 latch cleared");
        rd_chk(9'd9, 1, "R10 word kept");

        // R10: power drop in the same cycle as select fall.
        special(2'b11);
        frame(2'b01, 10'd12);
        send(32'h4321, 16);
        @(negedge clk) begin cs = 1'b0; pwr_good = 1'b0; di = 1'b0; end
        @(negedge clk) pwr_good = 1'b1;
        verify(1'b0, "R10 same cycle");
        rd_chk(9'd12, 1, "R10 same cycle word");

        // R11: clocks with DI high during programming are ignored.
        special(2'b11);
        wr(9'd20, 16'h0F0F);
        mem_m[20] = 16'h0F0F;
        cs_hi();
        for (int k = 0; k < 5; k++) pulse(1'b1, q, o);
        chk("R11 busy during clocks", {o, q}, 2'b10);
        repeat (PROG + 5) @(negedge clk);
        chk("R11 still ready", {dout_oe, dout}, 2'b11);
        cs_lo();
        rd_chk(9'd20, 1, "R11 word 20");

        // R8: write-all, single overwrite, full sweep with wrap.
        frame(2'b00, {2'b01, 8'h00});
        send(32'h3C3C, 16);
        cs_lo();
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 16'h3C3C;
        verify(1'b1, "R8 write-all");
        wr(9'd300, 16'h1234);
        mem_m[300] = 16'h1234;
        verify(1'b1, "R8 after write-all");
        rd_chk(9'd400, DEPTH + 1, "R5 R8 sweep");

        // R8: erase-all.
        special(2'b10);
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 16'hFFFF;
        verify(1'b1, "R8 erase-all");
        rd_chk(9'd510, 4, "R8 erased");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule